// File: doc/BRIEF.md
# Rotating Layer Fetch Address Generator

This block produces the stream of memory read addresses that a display overlay layer needs in order to fetch a cropped rectangle of its source image in output scan order. The rectangle can be presented in one of eight orientations: four rotations in quarter turns, and each of these followed by a left-right mirror of the output. Software-side setup supplies up to three plane base addresses, the crop origin, the window size, the line pitch counted in pixels and the number of bytes per pixel. A single start pulse then launches one full pass over the output raster.

Every output pixel yields one byte address, handed over on a valid/ready handshake, and the final address of the pass is flagged. For the luma plane the window is walked at full resolution. When a three-plane 4:2:0 source is selected and a chroma plane is requested, the crop origin, the window size and the pitch are all halved before the walk. Pixel data fetch, caching and colour format conversion are left to neighbouring blocks.

Top module: `lag_addr_gen`

## Requirements
- R1: After reset, addr_valid, addr_last and busy are all low.
- R2: A start pulse with busy low latches every configuration input. Later changes to those inputs, and start pulses that arrive while busy is high, have no effect on the pass in progress.
- R3: A start pulse whose effective window width or height is zero is ignored. busy stays low and no address is produced.
- R4: The address equals base + ((crop_y + sy) * pitch + (crop_x + sx)) * bpp. crop_x is crop_pos[15:0] and crop_y is crop_pos[31:16]. Width is win_size[15:0] and height is win_size[31:16]. The luma pitch in pixels is pitch_word[14:0], and bpp is the byte count per pixel.
- R5: orient codes 0 to 3 rotate by 0, 90, 180 and 270 degrees clockwise. For output pixel (ox, oy) the source pixel (sx, sy) is (ox, oy), (oy, H-1-ox), (W-1-ox, H-1-oy) and (W-1-oy, ox) respectively. Codes 1 and 3 give an output raster H wide and W tall.
- R6: orient codes 4 to 7 apply the same rotation as code-4 and then mirror the output left-right. Code 4 is a horizontal flip (W-1-ox, oy), code 5 is a transpose (oy, ox), code 6 is a vertical flip (ox, H-1-oy) and code 7 is an anti-transpose (W-1-oy, H-1-ox).
- R7: plane_sel selects base0, base1 or base2, and the value 3 also selects base2. When three_plane is high and plane_sel is not 0, the crop origin and the window size are each shifted right by one bit, and the pitch is pitch_word[29:15] shifted right by one bit.
- R8: Addresses come out in output raster order, row by row and left to right. While addr_valid is high and addr_ready is low, addr and addr_last hold their values.
- R9: addr_last is high only on the final address of a pass. After that address is accepted, addr_valid and busy are low in the next cycle.
- R10: A pass delivers exactly W*H addresses, where W and H are the effective window dimensions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one pass; taken only while busy is low |
| orient | input | 3 | Orientation code 0..7 |
| plane_sel | input | 2 | Plane to walk: 0 luma, 1 and 2 chroma |
| three_plane | input | 1 | Source is three-plane 4:2:0 |
| bpp | input | 3 | Bytes per pixel |
| base0 | input | 32 | Plane 0 base byte address |
| base1 | input | 32 | Plane 1 base byte address |
| base2 | input | 32 | Plane 2 base byte address |
| crop_pos | input | 32 | Crop origin, y high and x low |
| win_size | input | 32 | Window size, height high and width low |
| pitch_word | input | 30 | Luma pitch in pixels at [14:0], copy at [29:15] |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | addr holds a pending address |
| addr | output | 32 | Byte address of the current pixel |
| addr_last | output | 1 | Current address is the last of the pass |
| busy | output | 1 | A pass is in progress |

## Verification
On every cycle the assertions check that a stalled address and its last flag stay stable, that every address is at or above the latched plane base, that the last flag falls exactly on the W*H-th accepted beat, and that the block goes idle right after that beat. Only the bench scenarios can show that each orientation visits the right source pixel in the right order, that the chroma halving and the pitch copy are used, that a zero-size start is dropped, and that configuration changes and extra start pulses during a pass leave the pass untouched. The bench computes every expected address from the per-code formulas and compares each one as it is accepted.

// File: rtl/lag_pkg.sv
package lag_pkg;

  // Orientation code decomposition: a code is an optional axis swap
  // followed by optional reversal of the source x and y axes.
  function automatic logic orient_swaps(input logic [2:0] code);
    return code[0];
  endfunction

  function automatic logic orient_rev_x(input logic [2:0] code);
    return code[1] ^ (code[2] & ~code[0]);
  endfunction

  function automatic logic orient_rev_y(input logic [2:0] code);
    return (code[1] ^ code[0]) ^ (code[2] & code[0]);
  endfunction

endpackage

// File: rtl/lag_cfg_latch.sv
module lag_cfg_latch
  import lag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CRD_W   = 16,
  parameter int PITCH_W = 15,
  parameter int BPP_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [2:0]           orient,
  input  logic [1:0]           plane_sel,
  input  logic                 three_plane,
  input  logic [BPP_W-1:0]     bpp,
  input  logic [ADDR_W-1:0]    base0,
  input  logic [ADDR_W-1:0]    base1,
  input  logic [ADDR_W-1:0]    base2,
  input  logic [2*CRD_W-1:0]   crop_pos,
  input  logic [2*CRD_W-1:0]   win_size,
  input  logic [2*PITCH_W-1:0] pitch_word,
  output logic                 size_ok,
  output logic [2:0]           orient_q,
  output logic [BPP_W-1:0]     bpp_q,
  output logic [ADDR_W-1:0]    base_q,
  output logic [CRD_W-1:0]     cx_q,
  output logic [CRD_W-1:0]     cy_q,
  output logic [CRD_W-1:0]     w_q,
  output logic [CRD_W-1:0]     h_q,
  output logic [PITCH_W-1:0]   pitch_q,
  output logic [CRD_W-1:0]     ow_m1_q,
  output logic [CRD_W-1:0]     oh_m1_q
);

  logic               chroma;
  logic [CRD_W-1:0]   cx_d, cy_d, w_d, h_d;
  logic [PITCH_W-1:0] pitch_d;
  logic [ADDR_W-1:0]  base_d;

  assign chroma = three_plane && (plane_sel != 2'd0);

  always_comb begin
    cx_d    = crop_pos[CRD_W-1:0];
    cy_d    = crop_pos[2*CRD_W-1:CRD_W];
    w_d     = win_size[CRD_W-1:0];
    h_d     = win_size[2*CRD_W-1:CRD_W];
    pitch_d = pitch_word[PITCH_W-1:0];
    if (chroma) begin
      cx_d    = cx_d >> 1;
      cy_d    = cy_d >> 1;
      w_d     = w_d >> 1;
      h_d     = h_d >> 1;
      pitch_d = pitch_word[2*PITCH_W-1:PITCH_W] >> 1;
    end
    case (plane_sel)
      2'd0:    base_d = base0;
      2'd1:    base_d = base1;
      default: base_d = base2;
    endcase
  end

  assign size_ok = (w_d != '0) && (h_d != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      orient_q <= '0;
      bpp_q    <= '0;
      base_q   <= '0;
      cx_q     <= '0;
      cy_q     <= '0;
      w_q      <= '0;
      h_q      <= '0;
      pitch_q  <= '0;
      ow_m1_q  <= '0;
      oh_m1_q  <= '0;
    end else if (load) begin
      orient_q <= orient;
      bpp_q    <= bpp;
      base_q   <= base_d;
      cx_q     <= cx_d;
      cy_q     <= cy_d;
      w_q      <= w_d;
      h_q      <= h_d;
      pitch_q  <= pitch_d;
      ow_m1_q  <= orient_swaps(orient) ? h_d - 1'b1 : w_d - 1'b1;
      oh_m1_q  <= orient_swaps(orient) ? w_d - 1'b1 : h_d - 1'b1;
    end
  end

endmodule

// File: rtl/lag_orient_map.sv
module lag_orient_map
  import lag_pkg::*;
#(
  parameter int CRD_W = 16
) (
  input  logic [2:0]       orient,
  input  logic [CRD_W-1:0] ox,
  input  logic [CRD_W-1:0] oy,
  input  logic [CRD_W-1:0] w,
  input  logic [CRD_W-1:0] h,
  output logic [CRD_W-1:0] sx,
  output logic [CRD_W-1:0] sy
);

  logic [CRD_W-1:0] a, b;

  always_comb begin
    a  = orient_swaps(orient) ? oy : ox;
    b  = orient_swaps(orient) ? ox : oy;
    sx = orient_rev_x(orient) ? (w - 1'b1 - a) : a;
    sy = orient_rev_y(orient) ? (h - 1'b1 - b) : b;
  end

endmodule

// File: rtl/lag_addr_calc.sv
module lag_addr_calc #(
  parameter int ADDR_W  = 32,
  parameter int CRD_W   = 16,
  parameter int PITCH_W = 15,
  parameter int BPP_W   = 3
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [CRD_W-1:0]   cx,
  input  logic [CRD_W-1:0]   cy,
  input  logic [CRD_W-1:0]   sx,
  input  logic [CRD_W-1:0]   sy,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [BPP_W-1:0]   bpp,
  output logic [ADDR_W-1:0]  addr
);

  logic [ADDR_W-1:0] row, col, pix;

  always_comb begin
    row  = ADDR_W'(cy) + ADDR_W'(sy);
    col  = ADDR_W'(cx) + ADDR_W'(sx);
    pix  = row * ADDR_W'(pitch) + col;
    addr = base + pix * ADDR_W'(bpp);
  end

endmodule

// File: rtl/lag_addr_gen.sv
module lag_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int CRD_W   = 16,
  parameter int PITCH_W = 15,
  parameter int BPP_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [2:0]           orient,
  input  logic [1:0]           plane_sel,
  input  logic                 three_plane,
  input  logic [BPP_W-1:0]     bpp,
  input  logic [ADDR_W-1:0]    base0,
  input  logic [ADDR_W-1:0]    base1,
  input  logic [ADDR_W-1:0]    base2,
  input  logic [2*CRD_W-1:0]   crop_pos,
  input  logic [2*CRD_W-1:0]   win_size,
  input  logic [2*PITCH_W-1:0] pitch_word,
  input  logic                 addr_ready,
  output logic                 addr_valid,
  output logic [ADDR_W-1:0]    addr,
  output logic                 addr_last,
  output logic                 busy
);

  logic               size_ok, accept, advance, at_end;
  logic               active;
  logic [CRD_W-1:0]   ox, oy, sx, sy;
  logic [2:0]         c_orient;
  logic [BPP_W-1:0]   c_bpp;
  logic [ADDR_W-1:0]  c_base, next_addr;
  logic [CRD_W-1:0]   c_cx, c_cy, c_w, c_h, c_ow_m1, c_oh_m1;
  logic [PITCH_W-1:0] c_pitch;

  assign busy    = active | addr_valid;
  assign accept  = start && !busy && size_ok;
  assign advance = active && (!addr_valid || addr_ready);
  assign at_end  = (ox == c_ow_m1) && (oy == c_oh_m1);

  lag_cfg_latch #(
    .ADDR_W(ADDR_W), .CRD_W(CRD_W), .PITCH_W(PITCH_W), .BPP_W(BPP_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(accept),
    .orient(orient), .plane_sel(plane_sel), .three_plane(three_plane),
    .bpp(bpp), .base0(base0), .base1(base1), .base2(base2),
    .crop_pos(crop_pos), .win_size(win_size), .pitch_word(pitch_word),
    .size_ok(size_ok), .orient_q(c_orient), .bpp_q(c_bpp),
    .base_q(c_base), .cx_q(c_cx), .cy_q(c_cy), .w_q(c_w), .h_q(c_h),
    .pitch_q(c_pitch), .ow_m1_q(c_ow_m1), .oh_m1_q(c_oh_m1)
  );

  lag_orient_map #(.CRD_W(CRD_W)) u_map (
    .orient(c_orient), .ox(ox), .oy(oy), .w(c_w), .h(c_h),
    .sx(sx), .sy(sy)
  );

  lag_addr_calc #(
    .ADDR_W(ADDR_W), .CRD_W(CRD_W), .PITCH_W(PITCH_W), .BPP_W(BPP_W)
  ) u_calc (
    .base(c_base), .cx(c_cx), .cy(c_cy), .sx(sx), .sy(sy),
    .pitch(c_pitch), .bpp(c_bpp), .addr(next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      ox         <= '0;
      oy         <= '0;
      addr_valid <= 1'b0;
      addr       <= '0;
      addr_last  <= 1'b0;
    end else begin
      if (accept) begin
        active <= 1'b1;
        ox     <= '0;
        oy     <= '0;
      end else if (advance) begin
        if (ox == c_ow_m1) begin
          ox <= '0;
          oy <= oy + 1'b1;
        end else begin
          ox <= ox + 1'b1;
        end
        if (at_end) active <= 1'b0;
      end

      if (advance) begin
        addr_valid <= 1'b1;
        addr       <= next_addr;
        addr_last  <= at_end;
      end else if (addr_ready) begin
        addr_valid <= 1'b0;
        addr_last  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lag_addr_gen_chk.sv
module lag_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int CRD_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_last,
  input logic              busy,
  input logic [ADDR_W-1:0] base_q,
  input logic [CRD_W-1:0]  w_q,
  input logic [CRD_W-1:0]  h_q
);

  localparam int CW = 2 * CRD_W;

  logic [CW-1:0] beats;
  logic [CW-1:0] total;
  logic          xfer;

  assign xfer  = addr_valid && addr_ready;
  assign total = CW'(w_q) * CW'(h_q);

  always_ff @(posedge clk) begin
    if (rst)                   beats <= '0;
    else if (xfer && addr_last) beats <= '0;
    else if (xfer)             beats <= beats + 1'b1;
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr) && $stable(addr_last)));

  // R4
  above_base_chk: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> (addr >= base_q));

  // R10
  beat_total_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && addr_last) |-> (beats + 1'b1 == total));

  // R9
  early_last_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && !addr_last) |-> (beats + 1'b1 < total));

  // R9
  idle_after_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && addr_last) |=> (!addr_valid && !busy));

endmodule

bind lag_addr_gen lag_addr_gen_chk #(.ADDR_W(ADDR_W), .CRD_W(CRD_W)) u_chk (
  .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .addr(addr), .addr_last(addr_last), .busy(busy),
  .base_q(c_base), .w_q(c_w), .h_q(c_h)
);

// File: tb/sim_lag_addr_gen.sv
`timescale 1ns/1ps
module sim_lag_addr_gen;

  localparam int unsigned B0 = 32'h1000_0000;
  localparam int unsigned B1 = 32'h2000_0000;
  localparam int unsigned B2 = 32'h3000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  orient = '0;
  logic [1:0]  plane_sel = '0;
  logic        three_plane = 1'b0;
  logic [2:0]  bpp = 3'd1;
  logic [31:0] base0 = B0, base1 = B1, base2 = B2;
  logic [31:0] crop_pos = '0, win_size = '0;
  logic [29:0] pitch_word = '0;
  logic        addr_ready = 1'b0;
  logic        addr_valid, addr_last, busy;
  logic [31:0] addr;

  int unsigned n_run = 0, n_fail = 0;
  logic [7:0]  lfsr = 8'hA5;

  always #2 clk = ~clk;

  lag_addr_gen u0 (
    .clk(clk), .rst(rst), .start(start), .orient(orient),
    .plane_sel(plane_sel), .three_plane(three_plane), .bpp(bpp),
    .base0(base0), .base1(base1), .base2(base2),
    .crop_pos(crop_pos), .win_size(win_size), .pitch_word(pitch_word),
    .addr_ready(addr_ready), .addr_valid(addr_valid), .addr(addr),
    .addr_last(addr_last), .busy(busy)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned exp_addr(input int o, input int unsigned w, input int unsigned h,
      input int unsigned cx, input int unsigned cy, input int unsigned p, input int unsigned bp,
      input int unsigned base, input int unsigned k);
    int unsigned ow, ox, oy, sx, sy;
    ow = (o % 2 == 1) ? h : w;
    ox = k % ow;
    oy = k / ow;
    case (o)
      0: begin sx = ox;         sy = oy;         end
      1: begin sx = oy;         sy = h - 1 - ox; end
      2: begin sx = w - 1 - ox; sy = h - 1 - oy; end
      3: begin sx = w - 1 - oy; sy = ox;         end
      4: begin sx = w - 1 - ox; sy = oy;         end
      5: begin sx = oy;         sy = ox;         end
      6: begin sx = ox;         sy = h - 1 - oy; end
      default: begin sx = w - 1 - oy; sy = h - 1 - ox; end
    endcase
    return base + ((cy + sy) * p + (cx + sx)) * bp;
  endfunction

  task automatic run_case(input int o, input int pl, input bit three, input int bp,
      input int unsigned cx, input int unsigned cy, input int unsigned w, input int unsigned h,
      input int unsigned p, input bit disturb, input string req);
    int unsigned ew, eh, ecx, ecy, ep, eb, total, k;
    bit chroma;
    chroma = three && (pl != 0);
    ew  = chroma ? w >> 1 : w;
    eh  = chroma ? h >> 1 : h;
    ecx = chroma ? cx >> 1 : cx;
    ecy = chroma ? cy >> 1 : cy;
    ep  = chroma ? p >> 1 : p;
    eb  = (pl == 0) ? B0 : (pl == 1) ? B1 : B2;
    total = ew * eh;
    @(negedge clk);
    orient = 3'(o); plane_sel = 2'(pl); three_plane = three; bpp = 3'(bp);
    crop_pos = {16'(cy), 16'(cx)}; win_size = {16'(h), 16'(w)};
    pitch_word = {15'(p), 15'(p)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: scramble inputs after the pass was launched
    orient = ~orient; bpp = 3'd7; crop_pos = 32'h0003_0005;
    win_size = 32'h0002_0002; pitch_word = {15'd99, 15'd99}; plane_sel = 2'd2;
    k = 0;
    for (int it = 0; it < int'(total) * 6 + 40 && k < total; it++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      addr_ready = lfsr[0] | lfsr[3];
      start = disturb && (it == 2);
      if (addr_valid && addr_ready) begin
        chk(addr == exp_addr(o, ew, eh, ecx, ecy, ep, bp, eb, k), req, addr,
            exp_addr(o, ew, eh, ecx, ecy, ep, bp, eb, k));
        // R9: last flag only on the final address
        chk(addr_last == (k == total - 1), "R9", addr_last, (k == total - 1));
        k++;
      end
    end
    // R10: exact address count
    chk(k == total, "R10", k, total);
    @(negedge clk);
    addr_ready = 1'b0; start = 1'b0;
    chk(!addr_valid && !busy, "R9", {addr_valid, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!addr_valid && !addr_last && !busy, "R1", {addr_valid, addr_last, busy}, 0);

    // R3: zero width then zero height
    win_size = 32'h0003_0000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !addr_valid, "R3", {busy, addr_valid}, 0);
    win_size = 32'h0000_0004; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !addr_valid, "R3", {busy, addr_valid}, 0);

    // R4 plain walk, several bpp values
    run_case(0, 0, 1'b0, 1, 2, 1, 4, 3, 20, 1'b0, "R4");
    run_case(0, 0, 1'b0, 2, 0, 0, 5, 2, 16, 1'b0, "R4");
    run_case(0, 0, 1'b0, 4, 7, 3, 3, 3, 40, 1'b0, "R4");

    // R5 and R6 sweep: all codes over several window shapes
    for (int o = 0; o < 8; o++) begin
      run_case(o, 0, 1'b0, 4, 1, 2, 1, 1, 12, 1'b0, o < 4 ? "R5" : "R6");
      run_case(o, 0, 1'b0, 2, 3, 1, 3, 2, 12, 1'b0, o < 4 ? "R5" : "R6");
      run_case(o, 0, 1'b0, 1, 0, 4, 2, 5, 10, 1'b0, o < 4 ? "R5" : "R6");
      run_case(o, 0, 1'b0, 3, 2, 2, 4, 4, 9, 1'b0, o < 4 ? "R5" : "R6");
    end

    // R7 chroma halving and base selection
    for (int o = 0; o < 8; o++) begin
      run_case(o, 1, 1'b1, 1, 4, 6, 8, 6, 32, 1'b0, "R7");
      run_case(o, 2, 1'b1, 1, 2, 2, 6, 4, 24, 1'b0, "R7");
    end
    run_case(1, 3, 1'b1, 1, 2, 2, 6, 4, 24, 1'b0, "R7");
    run_case(2, 0, 1'b1, 1, 2, 2, 6, 4, 24, 1'b0, "R7");
    run_case(3, 1, 1'b0, 2, 1, 1, 3, 2, 24, 1'b0, "R7");

    // R2 start pulse while busy, R8 order under stalls
    run_case(5, 0, 1'b0, 2, 1, 1, 4, 3, 16, 1'b1, "R2");
    run_case(2, 0, 1'b0, 1, 0, 0, 6, 2, 8, 1'b1, "R8");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule